// File: doc/BRIEF.md
# Dual-Law SPI Serial Clock Generator

This block derives the serial clock of an SPI master from the system clock and tells the shift engine when to put out a bit and when to capture one. One divider setting, `divVal`, is read under one of two division laws. With `divMode` low the law is exponential: the system clock is divided by 2^(N+1), and only the low four bits of the setting count. With `divMode` high the law is linear: the ratio is 2×(N+1), and the whole eight-bit setting is used. In both laws the shortest serial clock period is two system clocks.

Clock polarity sets the level the serial clock rests at. Clock phase sets which edge of each bit carries the sample strobe and which carries the launch strobe. While `enable` is low the serial clock rests at its idle level and the internal counter is cleared. A divider or law change made while the clock runs takes effect only when the clock returns to idle, so a shortened pulse never reaches the pin. The idle level is captured only while the block is disabled, so a polarity change made mid-transfer cannot make a spurious edge.

Top module: `spiSclkDivider`

## Requirements
- R1: While `rstN` is low, `sclk` is 0 and both strobes are 0, whatever `cpol` is.
- R2: While `enable` is low, `sclk` equals `cpol` as sampled one system clock earlier, and both strobes stay 0. This holds even when `enable` falls while `sclk` is at its active level.
- R3: With `divMode` = 0, every `sclk` level lasts 2^N system clocks, where N is `divVal[3:0]`. Bits `divVal[7:4]` have no effect in this law.
- R4: With `divMode` = 1, every `sclk` level lasts N+1 system clocks, where N is `divVal[7:0]` and may take any value from 0 to 255.
- R5: With `divMode` = 1 and N = 0, `sclk` toggles on every system clock, which is the highest rate.
- R6: After `enable` rises, the first `sclk` edge comes on the h-th rising system clock edge that samples `enable` high, where h is the level length. Each later edge follows h clocks after the one before.
- R7: The idle level of `sclk` is high when `cpol` = 1 and low when `cpol` = 0.
- R8: Each `sclk` edge comes with exactly one strobe, high for one system clock in the same cycle that `sclk` shows its new level. With `cpha` = 0, edges that leave the idle level carry `sampleStb` and edges that return to idle carry `launchStb`. With `cpha` = 1 the roles swap.
- R9: A change of `divVal` or `divMode` while enabled is taken up at the next edge that returns `sclk` to idle. The idle and active levels that follow that edge use the new length, and the levels before it keep the old length.
- R10: A change of `cpol` while enabled does not change `sclk` or the strobe roles until `enable` is low again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Runs the serial clock when high |
| divVal | input | 8 | Divider setting N |
| divMode | input | 1 | 0: exponential law, 1: linear law |
| cpol | input | 1 | Idle level of the serial clock |
| cpha | input | 1 | Chooses which edge carries the sample strobe |
| sclk | output | 1 | Serial clock |
| launchStb | output | 1 | One-cycle pulse: shift engine puts out the next bit |
| sampleStb | output | 1 | One-cycle pulse: shift engine captures the incoming bit |

## Verification
The bench measures the length of each `sclk` level under both laws: the smallest and largest linear settings, a middle value, and an exponential setting with the upper divider bits set. These runs separate the linear law from the exponential one and show whether the ignored bits leak into the count. Every polarity and phase pair is run, so a swapped strobe role or a wrong idle level shows up at a specific edge. A divider and law change made just after the return to idle must give two levels at the old length and then two at the new length, which pins down the exact cycle the change is taken up. Dropping `enable` at the active level, and changing polarity mid-run, check that the idle level comes only from the disabled state.

// File: rtl/spiClkPkg.sv
package spiClkPkg;

  typedef struct packed {
    logic tick;
    logic leading;
  } edgeStrobeT;

endpackage

// File: rtl/spiClkCtrl.sv
module spiClkCtrl
  import spiClkPkg::*;
#(
  parameter int DIV_W = 8,
  parameter int EXP_W = 4,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [DIV_W-1:0] divVal,
  input  logic             divMode,
  output edgeStrobeT       stb
);

  logic [CNT_W-1:0] reqHalf;
  logic [CNT_W-1:0] latHalf;
  logic [CNT_W-1:0] cnt;
  logic             phase;
  logic             tick;

  // half-period length requested by the current settings
  always_comb begin
    if (divMode) reqHalf = CNT_W'(divVal) + CNT_W'(1);
    else         reqHalf = CNT_W'(1) << divVal[EXP_W-1:0];
  end

  assign tick        = enable && (cnt == latHalf - CNT_W'(1));
  assign stb.tick    = tick;
  assign stb.leading = ~phase;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt     <= '0;
      phase   <= 1'b0;
      latHalf <= CNT_W'(1);
    end else if (!enable) begin
      cnt     <= '0;
      phase   <= 1'b0;
      latHalf <= reqHalf;
    end else if (tick) begin
      cnt   <= '0;
      phase <= ~phase;
      if (phase) latHalf <= reqHalf;
    end else begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  // R3: the counter never runs past the latched half period
  a_r3_count_in_range: assert property (@(posedge clk) disable iff (!rstN)
    cnt < latHalf);

  // R9: the latched length moves only on a return-to-idle edge or while off
  a_r9_length_held: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !(tick && phase)) |=> $stable(latHalf));

  // R6: a fresh start always begins counting from zero
  a_r6_restart_from_zero: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !$past(enable)) |-> (cnt == '0 && !phase));

endmodule

// File: rtl/spiClkDp.sv
module spiClkDp
  import spiClkPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       cpol,
  input  logic       cpha,
  input  edgeStrobeT stb,
  output logic       sclk,
  output logic       launchStb,
  output logic       sampleStb
);

  logic sclkQ;
  logic idleQ;
  logic sampleNow;

  assign sampleNow = stb.leading ^ cpha;
  assign sclk      = sclkQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkQ     <= 1'b0;
      idleQ     <= 1'b0;
      launchStb <= 1'b0;
      sampleStb <= 1'b0;
    end else if (!enable) begin
      sclkQ     <= cpol;
      idleQ     <= cpol;
      launchStb <= 1'b0;
      sampleStb <= 1'b0;
    end else if (stb.tick) begin
      sclkQ     <= ~sclkQ;
      sampleStb <= sampleNow;
      launchStb <= ~sampleNow;
    end else begin
      launchStb <= 1'b0;
      sampleStb <= 1'b0;
    end
  end

  // R8: never two strobes at once
  a_r8_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    !(launchStb && sampleStb));

  // R2: disabled means idle level from cpol and no strobes
  a_r2_idle_when_off: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (sclk == $past(cpol) && !launchStb && !sampleStb));

  // R8: every running edge of sclk comes with a strobe
  a_r8_edge_has_strobe: assert property (@(posedge clk) disable iff (!rstN)
    (enable && $past(enable) && sclk != $past(sclk)) |-> (launchStb || sampleStb));

  // R10: the control's edge kind agrees with the captured idle level
  a_r10_phase_agrees: assert property (@(posedge clk) disable iff (!rstN)
    (enable && $past(enable) && stb.tick) |-> (stb.leading == (sclkQ == idleQ)));

endmodule

// File: rtl/spiSclkDivider.sv
module spiSclkDivider
  import spiClkPkg::*;
#(
  parameter int DIV_W = 8,
  parameter int EXP_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [DIV_W-1:0] divVal,
  input  logic             divMode,
  input  logic             cpol,
  input  logic             cpha,
  output logic             sclk,
  output logic             launchStb,
  output logic             sampleStb
);

  localparam int EXP_CNT_W = 1 << EXP_W;
  localparam int CNT_W     = (EXP_CNT_W > DIV_W + 1) ? EXP_CNT_W : DIV_W + 1;

  edgeStrobeT stb;

  spiClkCtrl #(
    .DIV_W(DIV_W),
    .EXP_W(EXP_W),
    .CNT_W(CNT_W)
  ) i_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .enable (enable),
    .divVal (divVal),
    .divMode(divMode),
    .stb    (stb)
  );

  spiClkDp i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .enable   (enable),
    .cpol     (cpol),
    .cpha     (cpha),
    .stb      (stb),
    .sclk     (sclk),
    .launchStb(launchStb),
    .sampleStb(sampleStb)
  );

endmodule

// File: tb/test_spiSclkDivider.sv
module test_spiSclkDivider;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enable = 1'b0;
  logic [7:0] divVal = 8'd0;
  logic       divMode = 1'b0;
  logic       cpol = 1'b1;
  logic       cpha = 1'b0;
  logic       sclk;
  logic       launchStb;
  logic       sampleStb;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  spiSclkDivider i_spiSclkDivider (
    .clk      (clk),
    .rstN     (rstN),
    .enable   (enable),
    .divVal   (divVal),
    .divMode  (divMode),
    .cpol     (cpol),
    .cpha     (cpha),
    .sclk     (sclk),
    .launchStb(launchStb),
    .sampleStb(sampleStb)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // configure with the block disabled, then confirm the idle level
  task automatic setup(input bit md, input logic [7:0] n, input bit pol, input bit pha);
    @(negedge clk);
    enable  = 1'b0;
    divMode = md;
    divVal  = n;
    cpol    = pol;
    cpha    = pha;
    repeat (2) @(negedge clk);
    check(sclk == pol && !launchStb && !sampleStb, "R2 R7 idle level while disabled",
          int'({sclk, launchStb, sampleStb}), int'({pol, 2'b00}));
  endtask

  // measure nLevels consecutive sclk levels, each expected expHalf clocks
  task automatic measureLevels(input int expHalf, input int nLevels, input bit pol,
                               input bit pha, input bit first, input string tag);
    logic prev;
    prev = sclk;
    for (int i = 0; i < nLevels; i++) begin
      int cnt;
      bit stray;
      bit leading;
      bit expSample;
      cnt = 0;
      stray = 1'b0;
      do begin
        @(negedge clk);
        cnt++;
        if (sclk === prev && (launchStb || sampleStb)) stray = 1'b1;
      end while (sclk === prev && cnt < 70000);
      if (first && i == 0)
        check(cnt == expHalf, {tag, " R6 first edge delay"}, cnt, expHalf);
      else
        check(cnt == expHalf, {tag, " level length"}, cnt, expHalf);
      check(!stray, {tag, " R8 no strobe between edges"}, int'(stray), 0);
      leading   = (prev == pol);
      expSample = leading ^ pha;
      check({launchStb, sampleStb} == {~expSample, expSample}, {tag, " R8 strobe role"},
            int'({launchStb, sampleStb}), int'({~expSample, expSample}));
      prev = sclk;
    end
  endtask

  task automatic startRun();
    @(negedge clk);
    enable = 1'b1;
  endtask

  task automatic tReset();
    repeat (3) @(negedge clk);
    check(sclk == 1'b0 && !launchStb && !sampleStb, "R1 reset state",
          int'({sclk, launchStb, sampleStb}), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(sclk == 1'b1, "R2 idle follows cpol after reset", int'(sclk), 1);
  endtask

  task automatic tExpLaw();
    setup(1'b0, 8'd4, 1'b0, 1'b0);
    startRun();
    measureLevels(16, 4, 1'b0, 1'b0, 1'b1, "R3 exp N=4");
    // upper bits ignored: 0xF2 behaves as N=2
    setup(1'b0, 8'hF2, 1'b1, 1'b1);
    startRun();
    measureLevels(4, 4, 1'b1, 1'b1, 1'b1, "R3 exp upper bits ignored");
  endtask

  task automatic tLinLaw();
    setup(1'b1, 8'd0, 1'b0, 1'b1);
    startRun();
    measureLevels(1, 6, 1'b0, 1'b1, 1'b1, "R5 linear N=0");
    setup(1'b1, 8'd6, 1'b1, 1'b0);
    startRun();
    measureLevels(7, 4, 1'b1, 1'b0, 1'b1, "R4 linear N=6");
    setup(1'b1, 8'd255, 1'b0, 1'b0);
    startRun();
    measureLevels(256, 2, 1'b0, 1'b0, 1'b1, "R4 linear N=255");
  endtask

  task automatic tDisableMid();
    setup(1'b1, 8'd3, 1'b1, 1'b0);
    startRun();
    measureLevels(4, 1, 1'b1, 1'b0, 1'b1, "R2 run before stop");
    enable = 1'b0;
    @(negedge clk);
    check(sclk == 1'b1 && !launchStb && !sampleStb, "R2 stop at active level",
          int'({sclk, launchStb, sampleStb}), 4);
    startRun();
    measureLevels(4, 2, 1'b1, 1'b0, 1'b1, "R6 restart after stop");
  endtask

  task automatic tRetune();
    setup(1'b1, 8'd1, 1'b0, 1'b0);
    startRun();
    measureLevels(2, 2, 1'b0, 1'b0, 1'b1, "R9 before change");
    divVal = 8'd3;
    measureLevels(2, 2, 1'b0, 1'b0, 1'b0, "R9 old length kept");
    measureLevels(4, 2, 1'b0, 1'b0, 1'b0, "R9 new linear length");
    divMode = 1'b0;
    measureLevels(4, 2, 1'b0, 1'b0, 1'b0, "R9 old length before law change");
    measureLevels(8, 2, 1'b0, 1'b0, 1'b0, "R9 new exp length");
  endtask

  task automatic tPolRun();
    setup(1'b1, 8'd2, 1'b0, 1'b1);
    startRun();
    measureLevels(3, 2, 1'b0, 1'b1, 1'b1, "R10 before cpol change");
    cpol = 1'b1;
    measureLevels(3, 2, 1'b0, 1'b1, 1'b0, "R10 cpol change ignored");
    check(sclk == 1'b0, "R10 idle level kept while running", int'(sclk), 0);
    enable = 1'b0;
    @(negedge clk);
    check(sclk == 1'b1, "R2 new cpol after disable", int'(sclk), 1);
  endtask

  initial begin
    tReset();
    tExpLaw();
    tLinLaw();
    tDisableMid();
    tRetune();
    tPolRun();
    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual %0d expected %0d", 150000, 0);
    summary();
  end

endmodule